// File: doc/BRIEF.md
# Block Memory Copy Engine

This engine carries out byte-wise block copies between two regions of a 16-bit address space. A start pulse loads a source pointer, a destination pointer, a 16-bit transfer count, an 8-bit flag byte and an 8-bit refresh counter. A direction bit selects whether both pointers move upward or downward. A repeat bit selects whether the engine stops after one transfer or keeps going until the count reaches zero. Each transfer reads one byte at the source pointer and then writes that byte at the destination pointer. After the write, the pointers and the count advance and the flag byte is updated.

Memory is reached over a valid/ready style request channel. `mem_req` is the valid. It stays high with a steady address, write flag and write data until the memory returns `mem_ack` for one cycle. Read data must be presented on `mem_rdata` in that acknowledge cycle. The memory applies back-pressure simply by holding `mem_ack` low, and any number of wait cycles is allowed. Every acknowledged access advances the low seven bits of the refresh counter. The engine reports `rep_taken` for each iteration that loops back, and `done` when it returns to idle.

Top module: `blkcpy_engine`

## Requirements
- R1: A start while idle loads the pointers, count, flag byte and refresh counter from the init ports and raises busy. A start while busy is ignored, and the loaded values change only through transfers.
- R2: Each transfer first issues a read (`mem_we`=0) at the source pointer and then a write (`mem_we`=1) at the destination pointer, carrying the byte just read. A pending request keeps its address and write flag until it is acknowledged.
- R3: After each write acknowledge, both pointers change by +1 when `dir_down`=0 and by -1 when `dir_down`=1, wrapping modulo 2^16.
- R4: After each write acknowledge, the count drops by 1 modulo 2^16. A start with count 0 still performs a transfer, leaving 0xFFFF.
- R5: After each transfer, flag bit 1 (subtract) and bit 4 (half-carry) are cleared. Bit 2 (parity/overflow) is set exactly when the new count is nonzero. Bits 0, 3, 5, 6 and 7 are kept.
- R6: With `repeat_en`=1 the engine starts another transfer while the new count is nonzero and stops when it is zero. With `repeat_en`=0 it stops after one transfer.
- R7: `rep_taken` pulses for one cycle after each write acknowledge that leads to another iteration, and never otherwise.
- R8: Each acknowledged memory access adds 1 modulo 128 to bits 6:0 of the refresh counter. Bit 7 keeps its loaded value.
- R9: `done` pulses for one cycle in the first cycle back in idle, and busy is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse |
| dir_down | input | 1 | 1 = pointers decrement, 0 = increment |
| repeat_en | input | 1 | 1 = loop until count is zero |
| src_init | input | 16 | Initial source pointer |
| dst_init | input | 16 | Initial destination pointer |
| cnt_init | input | 16 | Initial count |
| flags_init | input | 8 | Initial flag byte |
| rfsh_init | input | 8 | Initial refresh counter |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse on return to idle |
| rep_taken | output | 1 | One-cycle pulse per looping iteration |
| mem_req | output | 1 | Memory request valid |
| mem_ack | input | 1 | Memory acknowledge (ready), one cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with mem_ack |
| src_ptr | output | 16 | Current source pointer |
| dst_ptr | output | 16 | Current destination pointer |
| count | output | 16 | Current count |
| flags | output | 8 | Current flag byte |
| rfsh | output | 8 | Current refresh counter |

## Verification
The hardest case to reach is a start pulse arriving in the middle of a repeating copy. The engine must ignore it completely, so that the final pointers, count and memory image reflect only the first request. The bench reaches this case by giving the memory model several wait cycles per access. It then pulses start, with quite different init values, while a three-byte copy is still running. The refresh wrap across 127 with bit 7 set, and the count-zero start that wraps to 0xFFFF, are reached by choosing those values as init values.

// File: rtl/blkcpy_pkg.sv
package blkcpy_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } blk_state_t;

  localparam int FLG_SUB = 1;
  localparam int FLG_PV  = 2;
  localparam int FLG_HC  = 4;
endpackage

// File: rtl/blkcpy_ctrl.sv
module blkcpy_ctrl
  import blkcpy_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic repeat_en,
  input  logic mem_ack,
  input  logic last_xfer,
  output logic load,
  output logic rd_ack,
  output logic wr_ack,
  output logic busy,
  output logic is_write,
  output logic done,
  output logic rep_taken
);
  blk_state_t state_q, state_d;
  logic rep_q;
  logic loop_back;

  assign busy      = (state_q != ST_IDLE);
  assign is_write  = (state_q == ST_WRITE);
  assign load      = start && (state_q == ST_IDLE);
  assign rd_ack    = (state_q == ST_READ) && mem_ack;
  assign wr_ack    = (state_q == ST_WRITE) && mem_ack;
  assign loop_back = wr_ack && rep_q && !last_xfer;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start) state_d = ST_READ;
      ST_READ:  if (mem_ack) state_d = ST_WRITE;
      ST_WRITE: if (mem_ack) state_d = loop_back ? ST_READ : ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rep_q     <= 1'b0;
      done      <= 1'b0;
      rep_taken <= 1'b0;
    end else begin
      state_q   <= state_d;
      if (load) rep_q <= repeat_en;
      done      <= wr_ack && !loop_back;
      rep_taken <= loop_back;
    end
  end

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R7
  rep_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rep_taken |-> (state_q == ST_READ));
  // R6
  single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && !rep_q) |=> !busy);
endmodule

// File: rtl/blkcpy_regs.sv
module blkcpy_regs
  import blkcpy_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 8,
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          dir_down,
  input  logic [AW-1:0] src_init,
  input  logic [AW-1:0] dst_init,
  input  logic [CW-1:0] cnt_init,
  input  logic [FW-1:0] flags_init,
  input  logic          rd_ack,
  input  logic          wr_ack,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [CW-1:0] cnt_q,
  output logic [FW-1:0] flags_q,
  output logic [DW-1:0] data_q,
  output logic          last_xfer
);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic          dir_q;
  logic [AW-1:0] delta;
  logic [CW-1:0] cnt_next;
  logic [FW-1:0] flags_next;

  assign delta     = {{(AW-1){dir_q}}, 1'b1};
  assign cnt_next  = cnt_q - CNT_ONE;
  assign last_xfer = (cnt_q == CNT_ONE);

  always_comb begin
    flags_next          = flags_q;
    flags_next[FLG_SUB] = 1'b0;
    flags_next[FLG_HC]  = 1'b0;
    flags_next[FLG_PV]  = (cnt_next != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      flags_q <= '0;
      data_q  <= '0;
      dir_q   <= 1'b0;
    end else if (load) begin
      src_q   <= src_init;
      dst_q   <= dst_init;
      cnt_q   <= cnt_init;
      flags_q <= flags_init;
      dir_q   <= dir_down;
    end else begin
      if (rd_ack) data_q <= rdata;
      if (wr_ack) begin
        src_q   <= src_q + delta;
        dst_q   <= dst_q + delta;
        cnt_q   <= cnt_next;
        flags_q <= flags_next;
      end
    end
  end

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> cnt_q == $past(cnt_q) - CNT_ONE);
  // R5
  flag_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> (!flags_q[FLG_SUB] && !flags_q[FLG_HC] && (flags_q[FLG_PV] == (cnt_q != '0))));
  // R1
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !wr_ack) |=> ($stable(src_q) && $stable(dst_q) && $stable(cnt_q) && $stable(flags_q)));
  // R3
  ptr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> (src_q - $past(src_q)) == (dst_q - $past(dst_q)));
endmodule

// File: rtl/blkcpy_refresh.sv
module blkcpy_refresh #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [RW-1:0] init,
  input  logic          access,
  output logic [RW-1:0] rfsh_q
);
  localparam int LOW = RW - 1;

  always_ff @(posedge clk) begin
    if (!rst_n)
      rfsh_q <= '0;
    else if (load)
      rfsh_q <= init;
    else if (access)
      rfsh_q[LOW-1:0] <= rfsh_q[LOW-1:0] + 1'b1;
  end

  // R8
  rfsh_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> rfsh_q[LOW] == $past(rfsh_q[LOW]));
  // R8
  rfsh_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && access) |=> rfsh_q[LOW-1:0] == $past(rfsh_q[LOW-1:0]) + 1'b1);
endmodule

// File: rtl/blkcpy_engine.sv
module blkcpy_engine #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 8,
  parameter int FW = 8,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dir_down,
  input  logic          repeat_en,
  input  logic [AW-1:0] src_init,
  input  logic [AW-1:0] dst_init,
  input  logic [CW-1:0] cnt_init,
  input  logic [FW-1:0] flags_init,
  input  logic [RW-1:0] rfsh_init,
  output logic          busy,
  output logic          done,
  output logic          rep_taken,
  output logic          mem_req,
  input  logic          mem_ack,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] src_ptr,
  output logic [AW-1:0] dst_ptr,
  output logic [CW-1:0] count,
  output logic [FW-1:0] flags,
  output logic [RW-1:0] rfsh
);
  logic load, rd_ack, wr_ack, is_write, last_xfer;

  blkcpy_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .repeat_en (repeat_en),
    .mem_ack   (mem_ack),
    .last_xfer (last_xfer),
    .load      (load),
    .rd_ack    (rd_ack),
    .wr_ack    (wr_ack),
    .busy      (busy),
    .is_write  (is_write),
    .done      (done),
    .rep_taken (rep_taken)
  );

  blkcpy_regs #(.AW(AW), .CW(CW), .DW(DW), .FW(FW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .dir_down   (dir_down),
    .src_init   (src_init),
    .dst_init   (dst_init),
    .cnt_init   (cnt_init),
    .flags_init (flags_init),
    .rd_ack     (rd_ack),
    .wr_ack     (wr_ack),
    .rdata      (mem_rdata),
    .src_q      (src_ptr),
    .dst_q      (dst_ptr),
    .cnt_q      (count),
    .flags_q    (flags),
    .data_q     (mem_wdata),
    .last_xfer  (last_xfer)
  );

  blkcpy_refresh #(.RW(RW)) u_rfsh (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .init   (rfsh_init),
    .access (mem_req && mem_ack),
    .rfsh_q (rfsh)
  );

  assign mem_req  = busy;
  assign mem_we   = is_write;
  assign mem_addr = is_write ? dst_ptr : src_ptr;

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R2
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !mem_we) |=> (mem_req && mem_we));
endmodule

// File: tb/sim_blkcpy_engine.sv
module sim_blkcpy_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, dir_down = 0, repeat_en = 0;
  logic [15:0] src_init = 0, dst_init = 0, cnt_init = 0;
  logic [7:0] flags_init = 0, rfsh_init = 0;
  logic busy, done, rep_taken, mem_req, mem_we;
  logic mem_ack = 0;
  logic [15:0] mem_addr, src_ptr, dst_ptr, count;
  logic [7:0] mem_wdata, flags, rfsh;
  logic [7:0] mem_rdata = 0;

  logic [7:0] mem [0:255];
  int lat = 0, waitc = 0, n_acc = 0, order_err = 0;
  logic rd_seen = 0;
  logic [7:0] last_rd = 0;
  int n_tests = 0, n_fail = 0, n_rep = 0;

  always #10 clk = ~clk;

  blkcpy_engine u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_down(dir_down), .repeat_en(repeat_en),
    .src_init(src_init), .dst_init(dst_init), .cnt_init(cnt_init), .flags_init(flags_init),
    .rfsh_init(rfsh_init), .busy(busy), .done(done), .rep_taken(rep_taken),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .src_ptr(src_ptr), .dst_ptr(dst_ptr),
    .count(count), .flags(flags), .rfsh(rfsh)
  );

  // memory model: acknowledges after lat wait cycles, one-cycle ack
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 0;
        waitc = 0;
      end else if (mem_req) begin
        if (waitc >= lat) begin
          mem_ack = 1;
          n_acc++;
          if (mem_we) begin
            if (!rd_seen || mem_wdata != last_rd) order_err++;
            mem[mem_addr[7:0]] = mem_wdata;
            rd_seen = 0;
          end else begin
            if (rd_seen) order_err++;
            mem_rdata = mem[mem_addr[7:0]];
            last_rd = mem_rdata;
            rd_seen = 1;
          end
        end else waitc++;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic launch(logic [15:0] s, logic [15:0] d, logic [15:0] c, logic [7:0] f,
                        logic [7:0] r, logic dn, logic rp);
    @(negedge clk);
    src_init = s; dst_init = d; cnt_init = c; flags_init = f; rfsh_init = r;
    dir_down = dn; repeat_en = rp; start = 1;
    n_acc = 0; order_err = 0; n_rep = 0;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000; i++) begin
      if (done) break;
      if (rep_taken) n_rep++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R9 reset busy", busy, 0);
    chk("R9 reset done", done, 0);
    chk("R2 reset req", mem_req, 0);
    chk("R1 reset count", count, 0);
    chk("R8 reset rfsh", rfsh, 0);
  endtask

  task automatic t_single_inc();
    mem[8'h20] = 8'hA5;
    launch(16'h0020, 16'h0040, 16'd5, 8'hFF, 8'h10, 0, 0);
    chk("R1 busy after start", busy, 1);
    wait_done();
    chk("R9 done", done, 1);
    chk("R9 busy low", busy, 0);
    chk("R2 data copied", mem[8'h40], 8'hA5);
    chk("R2 access order", order_err, 0);
    chk("R6 single one xfer", n_acc, 2);
    chk("R3 src inc", src_ptr, 16'h0021);
    chk("R3 dst inc", dst_ptr, 16'h0041);
    chk("R4 count dec", count, 16'd4);
    chk("R5 flags nz", flags, 8'hED);
    chk("R7 no rep single", n_rep, 0);
    chk("R8 rfsh +2", rfsh, 8'h12);
    @(negedge clk);
    chk("R9 done one cycle", done, 0);
  endtask

  task automatic t_repeat_inc();
    for (int i = 0; i < 4; i++) mem[8'h10 + i] = 8'h30 + 8'(i);
    launch(16'h0010, 16'h0080, 16'd4, 8'h00, 8'h00, 0, 1);
    wait_done();
    for (int i = 0; i < 4; i++) chk("R6 repeat copy", mem[8'h80 + i], 8'h30 + 8'(i));
    chk("R2 order repeat", order_err, 0);
    chk("R6 accesses", n_acc, 8);
    chk("R3 src end", src_ptr, 16'h0014);
    chk("R3 dst end", dst_ptr, 16'h0084);
    chk("R4 count zero", count, 0);
    chk("R5 flags zero", flags, 8'h00);
    chk("R7 rep pulses", n_rep, 3);
  endtask

  task automatic t_repeat_dec();
    for (int i = 0; i < 3; i++) mem[8'h31 + i] = 8'hC1 + 8'(i);
    lat = 1;
    launch(16'h0033, 16'h0063, 16'd3, 8'hFF, 8'h00, 1, 1);
    wait_done();
    lat = 0;
    for (int i = 0; i < 3; i++) chk("R3 dec copy", mem[8'h61 + i], 8'hC1 + 8'(i));
    chk("R3 src dec", src_ptr, 16'h0030);
    chk("R3 dst dec", dst_ptr, 16'h0060);
    chk("R5 flags last", flags, 8'hE9);
    chk("R7 rep pulses dec", n_rep, 2);
  endtask

  task automatic t_count_zero();
    launch(16'h0050, 16'h0070, 16'd0, 8'h00, 8'h00, 0, 0);
    wait_done();
    chk("R4 zero wraps", count, 16'hFFFF);
    chk("R4 one xfer", n_acc, 2);
    chk("R5 pv set", flags, 8'h04);
  endtask

  task automatic t_wrap();
    launch(16'hFFFF, 16'h00F0, 16'd1, 8'h00, 8'h00, 0, 0);
    wait_done();
    chk("R3 src wrap up", src_ptr, 16'h0000);
    launch(16'h0000, 16'h00F4, 16'd1, 8'h00, 8'h00, 1, 0);
    wait_done();
    chk("R3 src wrap down", src_ptr, 16'hFFFF);
    chk("R3 dst down", dst_ptr, 16'h00F3);
  endtask

  task automatic t_refresh();
    launch(16'h0000, 16'h00A0, 16'd2, 8'h00, 8'hFE, 0, 1);
    wait_done();
    chk("R8 wrap keep msb", rfsh, 8'h82);
    launch(16'h0000, 16'h00A0, 16'd1, 8'h00, 8'h7F, 0, 0);
    wait_done();
    chk("R8 wrap msb zero", rfsh, 8'h01);
  endtask

  task automatic t_busy_start();
    for (int i = 0; i < 3; i++) mem[8'hB0 + i] = 8'h5A ^ 8'(i);
    lat = 3;
    launch(16'h00B0, 16'h00D0, 16'd3, 8'h00, 8'h00, 0, 1);
    repeat (5) @(negedge clk);
    src_init = 16'h1234; dst_init = 16'h4321; cnt_init = 16'd9; dir_down = 1; start = 1;
    @(negedge clk);
    start = 0;
    wait_done();
    lat = 0;
    chk("R1 ignored src", src_ptr, 16'h00B3);
    chk("R1 ignored dst", dst_ptr, 16'h00D3);
    chk("R1 ignored cnt", count, 16'd0);
    chk("R1 copy intact", mem[8'hD2], 8'h58);
    chk("R2 order busy", order_err, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single_inc();
    t_repeat_inc();
    t_repeat_dec();
    t_count_zero();
    t_wrap();
    t_refresh();
    t_busy_start();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule